// File: doc/BRIEF.md
# Phase Build-Out Controller

This controller sits beside a digital phase-locked loop and keeps the output clock from stepping in phase when the loop moves to a different input reference. It watches a set of candidate inputs, each with a valid flag and a priority value. When the reference in use goes invalid, it picks the best remaining valid input. It then asks the loop to coast in holdover while an external phase measurement block reports how far the new input sits from the output. The controller averages those reports and adds the result to a signed loop offset, so that the loop sees almost no phase error when holdover is released.

Software drives a two-bit mode: build-out active, build-out off, or build-out frozen. In the off and frozen modes, switches happen at once with no holdover. When no valid input remains, the controller holds the loop in holdover and flags that it has no reference. The next valid input that appears is taken as a new switch event.

Phase reports arrive on a valid/ready stream. `meas_ready` is low only in the single cycle in which the averaged result is committed. A source that sees it low keeps its word stable until it is taken. A word accepted while no measurement is running is discarded.

Top module: `pbo_ctrl`

## Requirements
- R1: During and right after reset: `holdover`=1, `no_ref`=1, `pbo_offset`=0, `sel_idx`=0.
- R2: A new input is chosen only from no-reference, or when the selected input's `ref_valid` bit is low. The choice is the valid input with the smallest priority value, and ties go to the lower index. A recovered higher-priority input does not cause a switch.
- R3: With mode 2'b00 (active), a switch event asserts `holdover` on the next edge. It stays high until the offset is committed.
- R4: The averaging count is 2^k, where k is `avg_log2` clamped to MAX_AVG_LOG2 and latched at the event. The average is the sum of the accepted samples shifted right arithmetically by k, which rounds toward minus infinity.
- R5: The average is added to `pbo_offset` with saturation to the signed OFF_W range. The offset changes on the same edge on which `holdover` falls.
- R6: `meas_ready` is low only in the commit cycle, which follows the acceptance of the last sample. Samples accepted outside a measurement do not change the offset.
- R7: With mode 2'b01 (off), the offset is cleared on the next edge and stays zero. Switches take place without holdover.
- R8: With mode 2'b10 or 2'b11 (frozen), the offset is not changed. Switches take place without holdover.
- R9: If the mode leaves active during a measurement, the measurement is abandoned and `holdover` falls on the next edge.
- R10: With no valid input, `holdover` and `no_ref` are both high. When an input becomes valid, it is selected and treated as a switch event.
- R11: If the selected input is lost during a measurement, the next best input is selected and the measurement restarts from an empty sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pbo_mode | input | 2 | 00 active, 01 off, 1x frozen |
| avg_log2 | input | AVG_W | log2 of samples to average |
| ref_valid | input | N_IN | Per-input valid flags |
| ref_prio | input | N_IN*PRIO_W | Per-input priority, lower value wins |
| meas_valid | input | 1 | Phase sample present |
| meas_ready | output | 1 | Phase sample accepted when high |
| meas_phase | input | PHASE_W | Signed phase of selected input minus output |
| sel_idx | output | IDX_W | Selected input index |
| holdover | output | 1 | Loop holdover request |
| no_ref | output | 1 | No valid input available |
| pbo_offset | output | OFF_W | Signed accumulated loop phase offset |

## Verification
The bench targets equal-priority ties and inputs that recover after being passed over. A wrong tie-break or revertive switching would show up as a different `sel_idx`. It drives averaging with odd negative sums and with an out-of-range `avg_log2`. A design that truncated toward zero or ignored the clamp would commit a different offset. Repeated events push the offset into both saturation limits, where wrap-around would flip its sign. The bench also removes the reference mid-measurement and changes the mode mid-measurement. A design that kept stale partial sums or held holdover too long would diverge from the model.

// File: rtl/pbo_pkg.sv
package pbo_pkg;
  typedef enum logic [1:0] {
    ST_NOREF = 2'd0,
    ST_LOCK  = 2'd1,
    ST_MEAS  = 2'd2,
    ST_APPLY = 2'd3
  } pbo_state_e;

  localparam logic [1:0] MODE_ON  = 2'b00;
  localparam logic [1:0] MODE_OFF = 2'b01;
endpackage

// File: rtl/pbo_ref_select.sv
module pbo_ref_select #(
  parameter int N_IN   = 4,
  parameter int PRIO_W = 3,
  parameter int IDX_W  = 2
) (
  input  logic [N_IN-1:0]        valid,
  input  logic [N_IN*PRIO_W-1:0] prio_flat,
  output logic                   found,
  output logic [IDX_W-1:0]       best_idx
);
  logic [PRIO_W-1:0] prio [N_IN];
  logic [PRIO_W-1:0] best_prio;

  for (genvar g = 0; g < N_IN; g++) begin : g_unpack
    assign prio[g] = prio_flat[g*PRIO_W +: PRIO_W];
  end

  // Ascending scan with strict compare: equal priority keeps the lower index.
  always_comb begin
    found     = 1'b0;
    best_idx  = '0;
    best_prio = '0;
    for (int i = 0; i < N_IN; i++) begin
      if (valid[i] && (!found || prio[i] < best_prio)) begin
        found     = 1'b1;
        best_idx  = IDX_W'(i);
        best_prio = prio[i];
      end
    end
  end
endmodule

// File: rtl/pbo_phase_avg.sv
module pbo_phase_avg #(
  parameter int PHASE_W = 12,
  parameter int MAX_K   = 4,
  parameter int K_W     = 3,
  parameter int ACC_W   = PHASE_W + MAX_K
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [K_W-1:0]            k_req,
  input  logic                      take,
  input  logic signed [PHASE_W-1:0] sample,
  output logic                      done,
  output logic signed [ACC_W-1:0]   avg
);
  localparam int CNT_W = MAX_K + 1;

  logic signed [ACC_W-1:0] acc;
  logic [CNT_W-1:0]        cnt;
  logic [CNT_W-1:0]        target;
  logic [K_W-1:0]          k;
  logic [K_W-1:0]          k_clamp;

  assign k_clamp = (k_req > K_W'(MAX_K)) ? K_W'(MAX_K) : k_req;
  assign target  = CNT_W'(1) << k;
  assign done    = take && ((cnt + CNT_W'(1)) == target);
  assign avg     = acc >>> k;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
      k   <= '0;
    end else if (start) begin
      acc <= '0;
      cnt <= '0;
      k   <= k_clamp;
    end else if (take) begin
      acc <= acc + ACC_W'(sample);
      cnt <= cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/pbo_offset_reg.sv
module pbo_offset_reg #(
  parameter int OFF_W = 14,
  parameter int ACC_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    add_en,
  input  logic signed [ACC_W-1:0] delta,
  output logic signed [OFF_W-1:0] offset
);
  localparam int SUM_W = ((OFF_W > ACC_W) ? OFF_W : ACC_W) + 1;
  localparam logic signed [SUM_W-1:0] HI =
    {{(SUM_W-OFF_W+1){1'b0}}, {(OFF_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] LO =
    {{(SUM_W-OFF_W+1){1'b1}}, {(OFF_W-1){1'b0}}};

  logic signed [SUM_W-1:0] sum;
  logic signed [OFF_W-1:0] sat;

  assign sum = SUM_W'(offset) + SUM_W'(delta);

  always_comb begin
    if (sum > HI)      sat = HI[OFF_W-1:0];
    else if (sum < LO) sat = LO[OFF_W-1:0];
    else               sat = sum[OFF_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      offset <= '0;
    else if (clear)  offset <= '0;
    else if (add_en) offset <= sat;
  end
endmodule

// File: rtl/pbo_ctrl.sv
module pbo_ctrl #(
  parameter int N_IN         = 4,
  parameter int PRIO_W       = 3,
  parameter int PHASE_W      = 12,
  parameter int MAX_AVG_LOG2 = 4,
  parameter int OFF_W        = 14,
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1,
  localparam int AVG_W = (MAX_AVG_LOG2 > 0) ? $clog2(MAX_AVG_LOG2 + 1) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                pbo_mode,
  input  logic [AVG_W-1:0]          avg_log2,
  input  logic [N_IN-1:0]           ref_valid,
  input  logic [N_IN*PRIO_W-1:0]    ref_prio,
  input  logic                      meas_valid,
  output logic                      meas_ready,
  input  logic signed [PHASE_W-1:0] meas_phase,
  output logic [IDX_W-1:0]          sel_idx,
  output logic                      holdover,
  output logic                      no_ref,
  output logic signed [OFF_W-1:0]   pbo_offset
);
  import pbo_pkg::*;

  localparam int ACC_W = PHASE_W + MAX_AVG_LOG2;

  pbo_state_e st, st_nxt;
  logic [IDX_W-1:0] sel_nxt;
  logic             found;
  logic [IDX_W-1:0] best_idx;
  logic             mode_on, mode_off;
  logic             lost, event_go, avg_start, take, avg_done;
  logic signed [ACC_W-1:0] avg;

  assign mode_on  = (pbo_mode == MODE_ON);
  assign mode_off = (pbo_mode == MODE_OFF);
  assign lost     = !ref_valid[sel_idx];

  pbo_ref_select #(.N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
    .valid     (ref_valid),
    .prio_flat (ref_prio),
    .found     (found),
    .best_idx  (best_idx)
  );

  always_comb begin
    st_nxt   = st;
    sel_nxt  = sel_idx;
    event_go = 1'b0;
    unique case (st)
      ST_NOREF: begin
        if (found) begin
          sel_nxt  = best_idx;
          event_go = 1'b1;
        end
      end
      ST_LOCK, ST_MEAS: begin
        if (lost) begin
          if (found) begin
            sel_nxt  = best_idx;
            event_go = 1'b1;
          end else begin
            st_nxt = ST_NOREF;
          end
        end else if (st == ST_MEAS) begin
          if (!mode_on)      st_nxt = ST_LOCK;
          else if (avg_done) st_nxt = ST_APPLY;
        end
      end
      ST_APPLY: st_nxt = ST_LOCK;
      default:  st_nxt = ST_NOREF;
    endcase
    if (event_go) st_nxt = mode_on ? ST_MEAS : ST_LOCK;
  end

  assign avg_start  = event_go && mode_on;
  assign meas_ready = (st != ST_APPLY);
  assign take       = (st == ST_MEAS) && !lost && mode_on && meas_valid && meas_ready;
  assign holdover   = (st != ST_LOCK);
  assign no_ref     = (st == ST_NOREF);

  pbo_phase_avg #(.PHASE_W(PHASE_W), .MAX_K(MAX_AVG_LOG2), .K_W(AVG_W), .ACC_W(ACC_W)) u_avg (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (avg_start),
    .k_req  (avg_log2),
    .take   (take),
    .sample (meas_phase),
    .done   (avg_done),
    .avg    (avg)
  );

  pbo_offset_reg #(.OFF_W(OFF_W), .ACC_W(ACC_W)) u_off (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (mode_off),
    .add_en ((st == ST_APPLY) && mode_on),
    .delta  (avg),
    .offset (pbo_offset)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_NOREF;
      sel_idx <= '0;
    end else begin
      st      <= st_nxt;
      sel_idx <= sel_nxt;
    end
  end
endmodule

// File: rtl/pbo_ctrl_chk.sv
module pbo_ctrl_chk #(
  parameter int N_IN  = 4,
  parameter int IDX_W = 2,
  parameter int OFF_W = 14
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [1:0]              pbo_mode,
  input logic [N_IN-1:0]         ref_valid,
  input logic                    meas_ready,
  input logic [IDX_W-1:0]        sel_idx,
  input logic                    holdover,
  input logic                    no_ref,
  input logic signed [OFF_W-1:0] pbo_offset
);
  AST_NOREF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    no_ref |-> holdover); // R10

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (pbo_mode == 2'b01) |=> (pbo_offset == '0)); // R7

  AST_FROZEN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    pbo_mode[1] |=> $stable(pbo_offset)); // R8

  AST_READY_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_ready |-> holdover); // R6

  AST_SEL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!no_ref && ref_valid[sel_idx]) |=> $stable(sel_idx)); // R2

  AST_OFF_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pbo_offset) |-> ($fell(holdover) || pbo_offset == '0)); // R5
endmodule

bind pbo_ctrl pbo_ctrl_chk #(.N_IN(N_IN), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pbo_mode   (pbo_mode),
  .ref_valid  (ref_valid),
  .meas_ready (meas_ready),
  .sel_idx    (sel_idx),
  .holdover   (holdover),
  .no_ref     (no_ref),
  .pbo_offset (pbo_offset)
);

// File: tb/pbo_ctrl_bench.sv
module pbo_ctrl_bench;
  localparam int N_IN = 4, PRIO_W = 3, PHASE_W = 12, MAXK = 4, OFF_W = 14;
  localparam int HI = (1 << (OFF_W - 1)) - 1;
  localparam int LO = -(1 << (OFF_W - 1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pbo_mode = 2'b00;
  logic [2:0] avg_log2 = 3'd2;
  logic [N_IN-1:0] ref_valid = '0;
  logic [N_IN*PRIO_W-1:0] ref_prio = {3'd5, 3'd1, 3'd1, 3'd3};
  logic meas_valid = 1'b0;
  logic meas_ready;
  logic signed [PHASE_W-1:0] meas_phase = '0;
  logic [1:0] sel_idx;
  logic holdover, no_ref;
  logic signed [OFF_W-1:0] pbo_offset;

  int checks = 0, fails = 0, cyc = 0;
  int ms = 0, msel = 0, moff = 0, macc = 0, mcnt = 0, mk = 0;

  always #2 clk = ~clk;

  pbo_ctrl u_pbo_ctrl (.*);

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic int sat(int v);
    return (v > HI) ? HI : (v < LO) ? LO : v;
  endfunction

  // Behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms = 0; msel = 0; moff = 0; macc = 0; mcnt = 0; mk = 0;
    end else begin
      int bi, bp, ns, nsel, noff;
      bit ev, on;
      bi = -1; bp = 1 << PRIO_W;
      for (int i = 0; i < N_IN; i++)
        if (ref_valid[i] && int'(ref_prio[i*PRIO_W +: PRIO_W]) < bp) begin
          bi = i; bp = int'(ref_prio[i*PRIO_W +: PRIO_W]);
        end
      on = (pbo_mode == 2'b00);
      ns = ms; nsel = msel; noff = moff; ev = 0;
      if (ms == 0) begin
        if (bi >= 0) begin nsel = bi; ev = 1; end
      end else if (ms == 1 || ms == 2) begin
        if (!ref_valid[msel]) begin
          if (bi >= 0) begin nsel = bi; ev = 1; end else ns = 0;
        end else if (ms == 2) begin
          if (!on) ns = 1;
          else if (meas_valid) begin
            macc += int'(meas_phase); mcnt++;
            if (mcnt == (1 << mk)) ns = 3;
          end
        end
      end else begin
        if (on) noff = sat(moff + (macc >>> mk));
        ns = 1;
      end
      if (ev) begin
        if (on) begin
          ns = 2; macc = 0; mcnt = 0;
          mk = (int'(avg_log2) > MAXK) ? MAXK : int'(avg_log2);
        end else ns = 1;
      end
      if (pbo_mode == 2'b01) noff = 0;
      ms = ns; msel = nsel; moff = noff;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2", "sel_idx", int'(sel_idx), msel);
      check("R3", "holdover", int'(holdover), int'(ms != 1));
      check("R10", "no_ref", int'(no_ref), int'(ms == 0));
      check("R6", "meas_ready", int'(meas_ready), int'(ms != 3));
      check("R5", "pbo_offset", int'(pbo_offset), moff);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic sample(int v);
    meas_valid = 1'b1; meas_phase = PHASE_W'(v); tick();
    meas_valid = 1'b0;
  endtask

  task automatic switch_ref();
    int s;
    s = msel;
    ref_valid[s] = 1'b0; tick();
    ref_valid[s] = 1'b1;
  endtask

  task automatic event_const(int k, int v);
    avg_log2 = 3'(k);
    switch_ref();
    for (int i = 0; i < (1 << ((k > MAXK) ? MAXK : k)); i++) sample(v);
    tick(2);
  endtask

  initial begin
    tick(3);
    check("R1", "reset holdover", int'(holdover), 1);
    check("R1", "reset no_ref", int'(no_ref), 1);
    check("R1", "reset offset", int'(pbo_offset), 0);
    check("R1", "reset sel", int'(sel_idx), 0);
    rst_n = 1'b1; tick(3);
    check("R10", "idle no_ref", int'(no_ref), 1);

    ref_valid = 4'b1111; tick();
    check("R2", "tie to lower index", int'(sel_idx), 1);
    check("R3", "holdover on event", int'(holdover), 1);
    sample(100); tick(); sample(101); sample(102); sample(103);
    check("R6", "ready low in commit", int'(meas_ready), 0);
    tick();
    check("R4", "first average", int'(pbo_offset), 101);
    check("R5", "holdover released", int'(holdover), 0);
    sample(500); tick(2);
    check("R6", "stray sample ignored", int'(pbo_offset), 101);

    avg_log2 = 3'd0;
    ref_valid = 4'b1101; tick();
    check("R2", "next by priority", int'(sel_idx), 2);
    sample(-50); tick();
    check("R5", "accumulate", int'(pbo_offset), 51);
    ref_valid = 4'b1111; tick(3);
    check("R2", "non-revertive", int'(sel_idx), 2);

    for (int e = 0; e < 5; e++) event_const(7, 2047);
    check("R5", "upper saturation", int'(pbo_offset), HI);

    avg_log2 = 3'd1; switch_ref(); sample(-3); sample(0); tick(2);
    check("R4", "floor rounding", int'(pbo_offset), 8189);

    for (int e = 0; e < 9; e++) event_const(0, -2048);
    check("R5", "lower saturation", int'(pbo_offset), LO);

    pbo_mode = 2'b10; switch_ref();
    check("R8", "frozen no holdover", int'(holdover), 0);
    check("R8", "frozen offset", int'(pbo_offset), LO);

    pbo_mode = 2'b00; avg_log2 = 3'd3; switch_ref(); sample(9); sample(9);
    pbo_mode = 2'b11; tick();
    check("R9", "abort releases", int'(holdover), 0);
    check("R9", "abort keeps offset", int'(pbo_offset), LO);

    pbo_mode = 2'b00; avg_log2 = 3'd2; switch_ref(); sample(1000);
    switch_ref();
    check("R11", "restart holdover", int'(holdover), 1);
    repeat (4) sample(40);
    tick();
    check("R11", "restart sum", int'(pbo_offset), LO + 40);

    pbo_mode = 2'b01; tick();
    check("R7", "off clears", int'(pbo_offset), 0);
    switch_ref();
    check("R7", "off no holdover", int'(holdover), 0);

    pbo_mode = 2'b00; ref_valid = 4'b0000; tick();
    check("R10", "lost all no_ref", int'(no_ref), 1);
    check("R10", "lost all holdover", int'(holdover), 1);
    ref_valid = 4'b1000; avg_log2 = 3'd0; tick();
    check("R10", "recover sel", int'(sel_idx), 3);
    check("R10", "recover measures", int'(holdover), 1);
    sample(-7); tick();
    check("R4", "single sample", int'(pbo_offset), -7);
    tick(3);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule